// File: doc/BRIEF.md
# Sliced Magnitude Comparator

This block compares two unsigned operands of the same width and raises exactly one of three outputs: operand A is greater, the two are equal, or A is less. It needs no clock and holds no state; the outputs follow the inputs through combinational logic.

The operands are cut into 4-bit nibbles. Each nibble has a small comparator of its own. That comparator takes a verdict in from the nibble below it and passes a verdict up to the nibble above. A nibble whose two halves differ decides the verdict itself. A nibble whose halves match passes the verdict from below unchanged. The lowest nibble starts from "equal". The width is a parameter and must be a positive multiple of four. For example, 8 bits gives a chain of two nibble stages.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i` as an unsigned number.
- R2: `eq_o` is 1 exactly when `a_i` and `b_i` are bit-for-bit identical.
- R3: `lt_o` is 1 exactly when `a_i` is less than `b_i` as an unsigned number.
- R4: For every operand pair, exactly one of `gt_o`, `eq_o` and `lt_o` is 1.
- R5: The highest nibble in which the operands differ decides the result. Lower nibbles that disagree the other way have no effect. Example: A=0x2000 and B=0x1FFF give greater.
- R6: When all the upper nibbles match, the verdict from the lowest differing nibble passes up through them unchanged. Example: A=0x0001 and B=0x0000 give greater.
- R7: With WIDTH=4 the chain has one stage. That stage starts from the equal verdict, and R1 to R4 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |

## Verification
At 8 bits, every one of the 65536 operand pairs is applied. Each pair is checked against the three unsigned relations and against the one-hot rule. This covers every combination of a low-nibble verdict and a high-nibble verdict. At 4 bits, every pair is applied as well, which isolates the single stage and its starting "equal" verdict. At 16 bits, random pairs are mixed with directed pairs. In the directed pairs the upper nibbles disagree against the lower ones, or match so that the lowest verdict must pass through three stages. These directed pairs separate a correct priority order from one that lets a lower nibble win.

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);
  localparam int NIB    = 4;
  localparam int STAGES = WIDTH / NIB;

  if (WIDTH < NIB || (WIDTH % NIB) != 0) begin : g_bad_width
    $error("mag_cmp_chain: WIDTH must be a positive multiple of 4");
  end

  logic [STAGES:0] gt_c, eq_c, lt_c;

  assign gt_c[0] = 1'b0;
  assign eq_c[0] = 1'b1;
  assign lt_c[0] = 1'b0;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NIB-1:0] an, bn;
    logic           loc_gt, loc_eq, loc_lt;

    assign an     = a_i[s*NIB +: NIB];
    assign bn     = b_i[s*NIB +: NIB];
    assign loc_gt = an > bn;
    assign loc_lt = an < bn;
    assign loc_eq = an == bn;

    assign gt_c[s+1] = loc_gt | (loc_eq & gt_c[s]);
    assign lt_c[s+1] = loc_lt | (loc_eq & lt_c[s]);
    assign eq_c[s+1] = loc_eq & eq_c[s];
  end

  assign gt_o = gt_c[STAGES];
  assign eq_o = eq_c[STAGES];
  assign lt_o = lt_c[STAGES];
endmodule

module mag_cmp_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             gt_o,
  input logic             eq_o,
  input logic             lt_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, gt_o, eq_o, lt_o})) begin
      p_gt_match_r1: assert (gt_o == (a_i > b_i));
      p_eq_match_r2: assert (eq_o == (a_i == b_i));
      p_lt_match_r3: assert (lt_o == (a_i < b_i));
      p_one_hot_r4:  assert ($countones({gt_o, eq_o, lt_o}) == 1);
    end
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_mag_cmp_chain.sv
module sim_mag_cmp_chain;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  a8 = '0,  b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4 = '0,  b4 = '0;
  logic g8, e8, l8, g16, e16, l16, g4, e4, l4;

  mag_cmp_chain #(.WIDTH(8))  u0 (.a_i(a8),  .b_i(b8),  .gt_o(g8),  .eq_o(e8),  .lt_o(l8));
  mag_cmp_chain #(.WIDTH(16)) u1 (.a_i(a16), .b_i(b16), .gt_o(g16), .eq_o(e16), .lt_o(l16));
  mag_cmp_chain #(.WIDTH(4))  u2 (.a_i(a4),  .b_i(b4),  .gt_o(g4),  .eq_o(e4),  .lt_o(l4));

  typedef struct packed {
    logic [2:0] x8;
    logic [2:0] x16;
    logic [2:0] x4;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int    n_chk = 0, n_bad = 0;

  function automatic logic [2:0] ref3(input logic [15:0] a, input logic [15:0] b);
    return {a > b, a == b, a < b};
  endfunction

  task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                       input logic [15:0] x16, input logic [15:0] y16,
                       input logic [3:0] x4, input logic [3:0] y4, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a8 = x8; b8 = y8; a16 = x16; b16 = y16; a4 = x4; b4 = y4;
    e.x8  = ref3({8'h0, x8}, {8'h0, y8});
    e.x16 = ref3(x16, y16);
    e.x4  = ref3({12'h0, x4}, {12'h0, y4});
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got gt/eq/lt=%b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      exp_t  e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({t, " w8"},  {g8, e8, l8},    e.x8);
      check({t, " w16"}, {g16, e16, l16}, e.x16);
      check({t, " w4"},  {g4, e4, l4},    e.x4);
      check("R4 one-hot w8",  {2'b0, $countones({g8, e8, l8}) == 1},    3'b001);
      check("R4 one-hot w16", {2'b0, $countones({g16, e16, l16}) == 1}, 3'b001);
    end
  end

  initial begin
    #(8 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2;
    check("R2 initial zero operands w8",  {g8, e8, l8},    3'b010);
    check("R2 initial zero operands w16", {g16, e16, l16}, 3'b010);

    // R5: the highest differing nibble wins over lower nibbles
    drive(8'h20, 8'h1F, 16'h2000, 16'h1FFF, 4'h0, 4'h0, "R5 upper greater lower less");
    drive(8'h1F, 8'h20, 16'h7FFF, 16'h8000, 4'h0, 4'h0, "R5 upper less lower greater");
    drive(8'h80, 8'h7F, 16'h8000, 16'h7FFF, 4'h0, 4'h0, "R5 msb decides");
    // R6: lowest verdict passes up through equal nibbles
    drive(8'h01, 8'h00, 16'h0001, 16'h0000, 4'h1, 4'h0, "R6 lowest nibble greater");
    drive(8'hA3, 8'hA4, 16'h1230, 16'h1234, 4'h3, 4'h4, "R6 lowest nibble less");
    // boundaries
    drive(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 4'hF, 4'hF, "R2 all ones equal");
    drive(8'h00, 8'hFF, 16'h0000, 16'hFFFF, 4'h0, 4'hF, "R3 zero versus max");
    drive(8'hFF, 8'h00, 16'hFFFF, 16'h0000, 4'hF, 4'h0, "R1 max versus zero");

    // R1 R2 R3 exhaustive at 8 bits; R7 exhaustive single stage; random at 16 bits
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (i[4:0] == 5'd0)
        drive(i[15:8], i[7:0], r, r, i[7:4], i[3:0], "R1 R2 R3 R7 sweep");
      else
        drive(i[15:8], i[7:0], r, 16'($urandom), i[7:4], i[3:0], "R1 R2 R3 R7 sweep");
    end

    @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule